// File: doc/BRIEF.md
# Linked Frame-Descriptor Fetch Engine

This block loads the control record for one display DMA channel at each frame boundary. When a frame starts on an enabled channel, it picks where the next record lives. An armed one-shot branch register takes precedence over the stored next-record pointer. The block then reads four consecutive 32-bit words through a single-outstanding valid/ready read port. The words land, in order, in the next-pointer, source-address, frame-tag and command registers, and a load-complete pulse follows the last word.

Both the record address and the fetched source address are checked against two memory windows. A record outside both windows is not fetched, which leaves the source cleared. A source that is zero or outside both windows raises a bus-error pulse and skips the frame. A valid source starts a frame transfer, which a neighbouring block handles. The command word decides whether that transfer is a palette load or pixel data, and whether start-of-frame and end-of-frame pulses are raised around it. When a branch is consumed, it disarms itself and can raise a branch pulse.

Top module: `fdesc_loader`

## Requirements
- R1: On an accepted frame start, four read requests are issued at the record address plus 0, 4, 8 and 12, in that order. The returned words are stored as next pointer, source address, frame tag and command. `ld_done` pulses for one cycle after the fourth word is captured, and is followed next cycle by either `xfer_go` or `ev_buserr`.
- R2: A write to the branch register stores data AND 0xFFFFFFF3. A write to the next-pointer register stores data AND 0xFFFFFFF0.
- R3: If branch bit 0 is set at an accepted frame start, the record is read from the address in branch bits 31:4 with the low 4 bits zero, and bit 0 is then cleared while the other bits keep their values. With bit 0 clear, the next pointer is used.
- R4: `ev_branch` pulses once when a branch is consumed with bit 1 set, and does not pulse when bit 1 is clear.
- R5: A record address A is fetchable when, for some window, A >= base and A + 16 <= base + size. The defaults are base 0x8000_0000 with size 0x0100_0000, and base 0x1000_0000 with size 0x100. Otherwise no request is issued. The source register is zeroed at every accepted frame start.
- R6: A source S is usable when it is non-zero and, for some window, S >= base and S <= base + size. An unusable source gives one `ev_buserr` pulse and no `xfer_go`, `ev_sof` or `ev_eof`.
- R7: For a usable source with command bit 26 clear, `xfer_go` pulses with `xfer_len` = command bits 20:2 times 4. `ev_sof` pulses in the same cycle if command bit 22 is set. `ev_eof` pulses in the cycle after `xfer_done` is sampled if command bit 21 is set.
- R8: With command bit 26 set, `xfer_go` pulses with `xfer_pal` = 1, and neither `ev_sof` nor `ev_eof` pulses.
- R9: While `chan_en` is low, `frame_start` issues no request, raises no event and changes no register.
- R10: A `frame_start` arriving while the engine is busy is ignored.
- R11: When a branch write and the consumption of an armed branch fall in the same cycle, the current frame uses the old branch address and the written value is kept.
- R12: A read request that is not accepted stays valid with a stable address until `rd_req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chan_en | input | 1 | Channel enable |
| frame_start | input | 1 | Frame boundary strobe |
| nxt_wr | input | 1 | Software write of next-pointer register |
| nxt_wdata | input | 32 | Next-pointer write data |
| brn_wr | input | 1 | Software write of branch register |
| brn_wdata | input | 32 | Branch write data |
| rd_req_valid | output | 1 | Read request valid |
| rd_req_ready | input | 1 | Read request accepted |
| rd_req_addr | output | 32 | Read byte address |
| rd_resp_valid | input | 1 | Read data valid |
| rd_resp_data | input | 32 | Read data |
| ld_done | output | 1 | Record load complete pulse |
| xfer_go | output | 1 | Frame transfer start pulse |
| xfer_pal | output | 1 | Transfer is a palette load |
| xfer_len | output | 21 | Transfer length in bytes |
| xfer_done | input | 1 | Frame transfer finished |
| nxt_desc | output | 32 | Next-pointer register |
| src_addr | output | 32 | Source address register |
| frame_id | output | 32 | Frame tag register |
| cmd_word | output | 32 | Command register |
| brn_reg | output | 32 | Branch register |
| ev_branch | output | 1 | Branch event pulse |
| ev_sof | output | 1 | Start-of-frame pulse |
| ev_eof | output | 1 | End-of-frame pulse |
| ev_buserr | output | 1 | Bus error pulse |
| busy | output | 1 | Engine not idle |

## Verification
A software write to the branch register can land in the same cycle that a frame start consumes the armed branch. The bench provokes this by raising `brn_wr` and `frame_start` on the same edge while bit 0 is armed. It then judges the first request address, the branch pulse and the branch value read afterwards. A second overlap is a frame start during a running transfer. That case is judged by the request count and the single `xfer_go`.

// File: rtl/fdesc_pkg.sv
package fdesc_pkg;
  localparam int WORD_W   = 32;
  localparam int NWORDS   = 4;
  localparam int IDX_W    = $clog2(NWORDS);
  localparam int LEN_W    = 21;

  localparam logic [WORD_W-1:0] BRN_MASK = 32'hFFFF_FFF3;
  localparam logic [WORD_W-1:0] NXT_MASK = 32'hFFFF_FFF0;
  localparam int BRN_ARM  = 0;
  localparam int BRN_EVT  = 1;
  localparam int CMD_EOF  = 21;
  localparam int CMD_SOF  = 22;
  localparam int CMD_PAL  = 26;

  typedef enum logic [2:0] {S_IDLE, S_REQ, S_WAIT, S_CHECK, S_XFER} fstate_t;

  // window hit: addr >= base and addr + span <= base + size, without wrap
  function automatic logic win_hit(input logic [WORD_W-1:0] addr,
                                   input logic [WORD_W-1:0] base,
                                   input logic [WORD_W-1:0] size,
                                   input logic [WORD_W-1:0] span);
    logic [WORD_W:0] lo, hi;
    lo = {1'b0, addr} + {1'b0, span};
    hi = {1'b0, base} + {1'b0, size};
    return (addr >= base) && (lo <= hi);
  endfunction

  function automatic logic [LEN_W-1:0] cmd_len(input logic [WORD_W-1:0] cmd);
    return {cmd[20:2], 2'b00};
  endfunction
endpackage

// File: rtl/fdesc_win_chk.sv
module fdesc_win_chk
  import fdesc_pkg::*;
#(
  parameter int NWIN = 2,
  parameter logic [NWIN-1:0][WORD_W-1:0] WIN_BASE = {32'h1000_0000, 32'h8000_0000},
  parameter logic [NWIN-1:0][WORD_W-1:0] WIN_SIZE = {32'h0000_0100, 32'h0100_0000},
  parameter logic [WORD_W-1:0] SPAN = '0
) (
  input  logic [WORD_W-1:0] addr,
  output logic              ok
);
  logic [NWIN-1:0] hit;
  for (genvar w = 0; w < NWIN; w++) begin : g_win
    assign hit[w] = win_hit(addr, WIN_BASE[w], WIN_SIZE[w], SPAN);
  end
  assign ok = |hit;
endmodule

// File: rtl/fdesc_branch.sv
module fdesc_branch
  import fdesc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [WORD_W-1:0] wdata,
  input  logic              take,
  output logic [WORD_W-1:0] q,
  output logic              ev
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q  <= '0;
      ev <= 1'b0;
    end else begin
      ev <= take & q[BRN_EVT];
      if (wr) q <= wdata & BRN_MASK;
      else if (take) q[BRN_ARM] <= 1'b0;
    end
  end

  // R3
  arm_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !wr) |=> !q[BRN_ARM]);
  // R11
  wr_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> (q == ($past(wdata) & BRN_MASK)));
  // R4
  ev_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev |-> $past(take));
endmodule

// File: rtl/fdesc_loader.sv
module fdesc_loader
  import fdesc_pkg::*;
#(
  parameter int NWIN = 2,
  parameter logic [NWIN-1:0][WORD_W-1:0] WIN_BASE = {32'h1000_0000, 32'h8000_0000},
  parameter logic [NWIN-1:0][WORD_W-1:0] WIN_SIZE = {32'h0000_0100, 32'h0100_0000}
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chan_en,
  input  logic              frame_start,
  input  logic              nxt_wr,
  input  logic [WORD_W-1:0] nxt_wdata,
  input  logic              brn_wr,
  input  logic [WORD_W-1:0] brn_wdata,
  output logic              rd_req_valid,
  input  logic              rd_req_ready,
  output logic [WORD_W-1:0] rd_req_addr,
  input  logic              rd_resp_valid,
  input  logic [WORD_W-1:0] rd_resp_data,
  output logic              ld_done,
  output logic              xfer_go,
  output logic              xfer_pal,
  output logic [LEN_W-1:0]  xfer_len,
  input  logic              xfer_done,
  output logic [WORD_W-1:0] nxt_desc,
  output logic [WORD_W-1:0] src_addr,
  output logic [WORD_W-1:0] frame_id,
  output logic [WORD_W-1:0] cmd_word,
  output logic [WORD_W-1:0] brn_reg,
  output logic              ev_branch,
  output logic              ev_sof,
  output logic              ev_eof,
  output logic              ev_buserr,
  output logic              busy
);
  localparam logic [WORD_W-1:0] DESC_SPAN = WORD_W'(NWORDS * 4);
  localparam logic [IDX_W-1:0]  LAST_IDX  = IDX_W'(NWORDS - 1);

  fstate_t           state;
  logic [IDX_W-1:0]  idx_q;
  logic [WORD_W-1:0] base_q, nxt_q, src_q, fid_q, cmd_q;
  logic              ld_done_q, go_q, sof_q, eof_q, ber_q;

  // named internal events
  logic              start_ok, take_brn, desc_ok, src_ok, src_bad;
  logic [WORD_W-1:0] pick_addr;

  assign start_ok  = (state == S_IDLE) && frame_start && chan_en;
  assign take_brn  = start_ok && brn_reg[BRN_ARM];
  assign pick_addr = brn_reg[BRN_ARM] ? {brn_reg[WORD_W-1:4], 4'b0000} : nxt_q;
  assign src_bad   = (src_q == '0) || !src_ok;

  fdesc_branch u_brn (
    .clk(clk), .rst_n(rst_n), .wr(brn_wr), .wdata(brn_wdata),
    .take(take_brn), .q(brn_reg), .ev(ev_branch)
  );

  fdesc_win_chk #(.NWIN(NWIN), .WIN_BASE(WIN_BASE), .WIN_SIZE(WIN_SIZE), .SPAN(DESC_SPAN))
    u_desc_win (.addr(pick_addr), .ok(desc_ok));

  fdesc_win_chk #(.NWIN(NWIN), .WIN_BASE(WIN_BASE), .WIN_SIZE(WIN_SIZE), .SPAN('0))
    u_src_win (.addr(src_q), .ok(src_ok));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      idx_q <= '0;
      base_q <= '0;
      nxt_q <= '0;
      src_q <= '0;
      fid_q <= '0;
      cmd_q <= '0;
      ld_done_q <= 1'b0;
      go_q <= 1'b0;
      sof_q <= 1'b0;
      eof_q <= 1'b0;
      ber_q <= 1'b0;
    end else begin
      ld_done_q <= 1'b0;
      go_q <= 1'b0;
      sof_q <= 1'b0;
      eof_q <= 1'b0;
      ber_q <= 1'b0;
      if (nxt_wr) nxt_q <= nxt_wdata & NXT_MASK;
      unique case (state)
        S_IDLE: if (start_ok) begin
          base_q <= pick_addr;
          src_q  <= '0;
          idx_q  <= '0;
          state  <= desc_ok ? S_REQ : S_CHECK;
        end
        S_REQ: if (rd_req_ready) state <= S_WAIT;
        S_WAIT: if (rd_resp_valid) begin
          case (idx_q)
            2'd0:    nxt_q <= rd_resp_data;
            2'd1:    src_q <= rd_resp_data;
            2'd2:    fid_q <= rd_resp_data;
            default: cmd_q <= rd_resp_data;
          endcase
          if (idx_q == LAST_IDX) begin
            ld_done_q <= 1'b1;
            state <= S_CHECK;
          end else begin
            idx_q <= idx_q + 1'b1;
            state <= S_REQ;
          end
        end
        S_CHECK: if (src_bad) begin
          ber_q <= 1'b1;
          state <= S_IDLE;
        end else begin
          go_q  <= 1'b1;
          sof_q <= cmd_q[CMD_SOF] & ~cmd_q[CMD_PAL];
          state <= S_XFER;
        end
        S_XFER: if (xfer_done) begin
          eof_q <= cmd_q[CMD_EOF] & ~cmd_q[CMD_PAL];
          state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign rd_req_valid = (state == S_REQ);
  assign rd_req_addr  = base_q + WORD_W'({idx_q, 2'b00});
  assign ld_done   = ld_done_q;
  assign xfer_go   = go_q;
  assign xfer_pal  = cmd_q[CMD_PAL];
  assign xfer_len  = cmd_len(cmd_q);
  assign nxt_desc  = nxt_q;
  assign src_addr  = src_q;
  assign frame_id  = fid_q;
  assign cmd_word  = cmd_q;
  assign ev_sof    = sof_q;
  assign ev_eof    = eof_q;
  assign ev_buserr = ber_q;
  assign busy      = (state != S_IDLE);

  // R12
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_valid && !rd_req_ready) |=> (rd_req_valid && $stable(rd_req_addr)));
  // R1
  done_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld_done |=> (xfer_go || ev_buserr));
  // R8
  pal_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_sof || ev_eof) |-> !xfer_pal);
  // R6
  ber_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_buserr |-> (!xfer_go && !ev_sof && !ev_eof));
  // R9
  idle_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !chan_en) |=> !busy);
  // R5
  src_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !$past(busy)) |-> (src_addr == '0));
endmodule

// File: tb/fdesc_loader_test.sv
`timescale 1ns/1ps
module fdesc_loader_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic chan_en = 1'b0, frame_start = 1'b0;
  logic nxt_wr = 1'b0, brn_wr = 1'b0;
  logic [31:0] nxt_wdata = '0, brn_wdata = '0;
  logic rd_req_valid, rd_req_ready = 1'b1;
  logic [31:0] rd_req_addr;
  logic rd_resp_valid = 1'b0;
  logic [31:0] rd_resp_data = '0;
  logic ld_done, xfer_go, xfer_pal, xfer_done = 1'b0;
  logic [20:0] xfer_len;
  logic [31:0] nxt_desc, src_addr, frame_id, cmd_word, brn_reg;
  logic ev_branch, ev_sof, ev_eof, ev_buserr, busy;

  fdesc_loader uut (
    .clk(clk), .rst_n(rst_n), .chan_en(chan_en), .frame_start(frame_start),
    .nxt_wr(nxt_wr), .nxt_wdata(nxt_wdata), .brn_wr(brn_wr), .brn_wdata(brn_wdata),
    .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready), .rd_req_addr(rd_req_addr),
    .rd_resp_valid(rd_resp_valid), .rd_resp_data(rd_resp_data),
    .ld_done(ld_done), .xfer_go(xfer_go), .xfer_pal(xfer_pal), .xfer_len(xfer_len),
    .xfer_done(xfer_done), .nxt_desc(nxt_desc), .src_addr(src_addr), .frame_id(frame_id),
    .cmd_word(cmd_word), .brn_reg(brn_reg), .ev_branch(ev_branch), .ev_sof(ev_sof),
    .ev_eof(ev_eof), .ev_buserr(ev_buserr), .busy(busy)
  );

  always #2.5 clk = ~clk;

  int n_tests = 0, n_fail = 0;
  int cyc = 0;
  bit finished = 0;
  bit stall = 0;
  logic [31:0] mem [0:63];
  int n_req, n_br, n_sof, n_eof, n_ber, n_done, n_go;
  int sof_cyc, eof_cyc, go_cyc, xd_cyc;
  logic [31:0] first_addr, last_addr;
  logic pal_seen;
  logic [20:0] go_len;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic clr();
    n_req = 0; n_br = 0; n_sof = 0; n_eof = 0; n_ber = 0; n_done = 0; n_go = 0;
    sof_cyc = -1; eof_cyc = -1; go_cyc = -1; xd_cyc = -1;
    first_addr = '0; last_addr = '0; pal_seen = 1'b0; go_len = '0;
  endtask

  // memory responder and event monitor
  initial begin
    bit pend;
    logic [31:0] paddr;
    pend = 0; paddr = '0;
    clr();
    forever begin
      @(negedge clk);
      rd_resp_valid = 1'b0;
      if (pend) begin
        rd_resp_valid = 1'b1;
        rd_resp_data = mem[paddr[7:2]];
        pend = 0;
      end
      rd_req_ready = stall ? cyc[0] : 1'b1;
      if (rd_req_valid && rd_req_ready) begin
        pend = 1; paddr = rd_req_addr;
        if (n_req == 0) first_addr = rd_req_addr;
        last_addr = rd_req_addr;
        n_req++;
      end
      if (ev_branch) n_br++;
      if (ev_sof) begin n_sof++; sof_cyc = cyc; end
      if (ev_eof) begin n_eof++; eof_cyc = cyc; end
      if (ev_buserr) n_ber++;
      if (ld_done) n_done++;
      if (xfer_go) begin n_go++; go_cyc = cyc; pal_seen = xfer_pal; go_len = xfer_len; end
    end
  end

  // frame transfer responder
  initial begin
    forever begin
      @(negedge clk);
      if (xfer_go) begin
        repeat (2) @(negedge clk);
        xfer_done = 1'b1; xd_cyc = cyc;
        @(negedge clk);
        xfer_done = 1'b0;
      end
    end
  end

  task automatic sw_nxt(input logic [31:0] d);
    @(negedge clk); nxt_wr = 1'b1; nxt_wdata = d;
    @(negedge clk); nxt_wr = 1'b0;
  endtask

  task automatic sw_brn(input logic [31:0] d);
    @(negedge clk); brn_wr = 1'b1; brn_wdata = d;
    @(negedge clk); brn_wr = 1'b0;
  endtask

  task automatic run_frame(input bit poke, input bit collide, input logic [31:0] cdata);
    @(negedge clk);
    clr();
    frame_start = 1'b1;
    if (collide) begin brn_wr = 1'b1; brn_wdata = cdata; end
    @(negedge clk);
    frame_start = 1'b0; brn_wr = 1'b0;
    for (int i = 0; i < 300 && busy; i++) begin
      @(negedge clk);
      frame_start = poke && xfer_go;
    end
    frame_start = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 reset busy", busy, 0);
    chk("R1 reset req", rd_req_valid, 0);
    chk("R2 reset nxt", nxt_desc, 0);
    chk("R3 reset brn", brn_reg, 0);
    chk("R5 reset src", src_addr, 0);
  endtask

  task automatic t_chain();
    stall = 1;
    sw_nxt(32'h8000_0010);
    run_frame(0, 0, '0);
    stall = 0;
    chk("R1 req count", n_req, 4);
    chk("R1 first addr", first_addr, 32'h8000_0010);
    chk("R1 last addr", last_addr, 32'h8000_001C);
    chk("R12 stalled fetch nxt", nxt_desc, 32'h8000_0020);
    chk("R1 src", src_addr, 32'h8000_0080);
    chk("R1 fid", frame_id, 32'h55);
    chk("R1 cmd", cmd_word, 32'h0060_0040);
    chk("R1 done", n_done, 1);
    chk("R7 go", n_go, 1);
    chk("R7 len", 32'(go_len), 32'h40);
    chk("R7 sof", n_sof, 1);
    chk("R7 sof with go", sof_cyc, go_cyc);
    chk("R7 eof", n_eof, 1);
    chk("R7 eof timing", eof_cyc, xd_cyc + 1);
    chk("R6 no ber", n_ber, 0);
  endtask

  task automatic t_palette();
    run_frame(0, 0, '0);
    chk("R8 first addr", first_addr, 32'h8000_0020);
    chk("R8 go", n_go, 1);
    chk("R8 pal", pal_seen, 1);
    chk("R8 no sof", n_sof, 0);
    chk("R8 no eof", n_eof, 0);
    chk("R8 fid", frame_id, 32'h66);
  endtask

  task automatic t_branch_ev();
    sw_brn(32'h8000_003F);
    chk("R2 brn mask", brn_reg, 32'h8000_0033);
    run_frame(0, 0, '0);
    chk("R3 brn addr", first_addr, 32'h8000_0030);
    chk("R4 brn event", n_br, 1);
    chk("R3 arm cleared", brn_reg, 32'h8000_0032);
    chk("R3 fid", frame_id, 32'h77);
    chk("R7 eof only", n_eof, 1);
    chk("R7 no sof", n_sof, 0);
  endtask

  task automatic t_branch_quiet();
    sw_brn(32'h8000_0031);
    run_frame(0, 0, '0);
    chk("R3 quiet addr", first_addr, 32'h8000_0030);
    chk("R4 no event", n_br, 0);
    chk("R3 quiet cleared", brn_reg, 32'h8000_0030);
  endtask

  task automatic t_nxt_mask();
    sw_nxt(32'h8000_001F);
    chk("R2 nxt mask", nxt_desc, 32'h8000_0010);
    run_frame(0, 0, '0);
    chk("R3 unarmed uses nxt", first_addr, 32'h8000_0010);
  endtask

  task automatic t_src_bad();
    sw_nxt(32'h8000_0040);
    run_frame(0, 0, '0);
    chk("R6 zero req", n_req, 4);
    chk("R6 zero ber", n_ber, 1);
    chk("R6 zero no go", n_go, 0);
    chk("R6 zero no sof", n_sof, 0);
    sw_nxt(32'h8000_0050);
    run_frame(0, 0, '0);
    chk("R6 outside ber", n_ber, 1);
    chk("R6 outside no go", n_go, 0);
  endtask

  task automatic t_desc_out();
    sw_nxt(32'h9000_0000);
    run_frame(0, 0, '0);
    chk("R5 no req", n_req, 0);
    chk("R5 src cleared", src_addr, 0);
    chk("R5 ber", n_ber, 1);
    sw_nxt(32'h1000_0100);
    run_frame(0, 0, '0);
    chk("R5 edge+16 no req", n_req, 0);
  endtask

  task automatic t_edges();
    sw_nxt(32'h1000_00F0);
    run_frame(0, 0, '0);
    chk("R5 last slot req", n_req, 4);
    chk("R5 last slot addr", last_addr, 32'h1000_00FC);
    chk("R6 src at top ok", n_ber, 0);
    chk("R6 src at top go", n_go, 1);
    chk("R7 sof", n_sof, 1);
    sw_nxt(32'h1000_00E0);
    run_frame(0, 0, '0);
    chk("R6 src past top ber", n_ber, 1);
    chk("R6 src past top no go", n_go, 0);
  endtask

  task automatic t_disabled();
    logic [31:0] s0, f0;
    sw_nxt(32'h8000_0010);
    s0 = src_addr; f0 = frame_id;
    chan_en = 1'b0;
    run_frame(0, 0, '0);
    chk("R9 no req", n_req, 0);
    chk("R9 no ber", n_ber, 0);
    chk("R9 no go", n_go, 0);
    chk("R9 src kept", src_addr, s0);
    chk("R9 fid kept", frame_id, f0);
    chan_en = 1'b1;
  endtask

  task automatic t_collide();
    sw_brn(32'h8000_0033);
    run_frame(0, 1, 32'h8000_0071);
    chk("R11 old addr used", first_addr, 32'h8000_0030);
    chk("R11 event", n_br, 1);
    chk("R11 write kept", brn_reg, 32'h8000_0071);
    sw_brn(32'h0);
  endtask

  task automatic t_busy();
    sw_nxt(32'h8000_0010);
    run_frame(1, 0, '0);
    chk("R10 req count", n_req, 4);
    chk("R10 one go", n_go, 1);
    chk("R10 one done", n_done, 1);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = '0;
    mem[4]  = 32'h8000_0020; mem[5]  = 32'h8000_0080; mem[6]  = 32'h55; mem[7]  = 32'h0060_0040;
    mem[8]  = 32'h8000_0010; mem[9]  = 32'h8000_0090; mem[10] = 32'h66; mem[11] = 32'h0460_0400;
    mem[12] = 32'h8000_0010; mem[13] = 32'h8000_00A0; mem[14] = 32'h77; mem[15] = 32'h0020_0020;
    mem[16] = 32'h8000_0010; mem[17] = 32'h0;         mem[18] = 32'h88; mem[19] = 32'h0060_0000;
    mem[20] = 32'h8000_0010; mem[21] = 32'h4000_0000; mem[22] = 32'h99; mem[23] = 32'h0060_0000;
    mem[56] = 32'h8000_0010; mem[57] = 32'h1000_0104; mem[58] = 32'hBB; mem[59] = 32'h0040_0000;
    mem[60] = 32'h8000_0010; mem[61] = 32'h1000_0100; mem[62] = 32'hAA; mem[63] = 32'h0040_0000;
    repeat (4) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    chan_en = 1'b1;
    repeat (2) @(negedge clk);
    t_chain();
    t_palette();
    t_branch_ev();
    t_branch_quiet();
    t_nxt_mask();
    t_src_bad();
    t_desc_out();
    t_edges();
    t_disabled();
    t_collide();
    t_busy();
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_tests++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule